// File: doc/BRIEF.md
# Banked GPIO Controller with Edge and Level Interrupts

This block is a memory-mapped general-purpose I/O controller. Its pins are split into banks of 32. Each bank has its own registers for pin direction, input inversion and output data. Output bits can also be changed through two side registers: one that raises the selected bits and one that lowers them. Each pin has four separate trigger enables: rising edge, falling edge, high level and low level. A pending bit is set when an enabled trigger fires, and software clears it by writing 1 to it.

The pin inputs pass through a two-stage synchronizer before they are sensed. The sensed value is the synchronized input XOR the inversion bit. A read-only register shows, for each pending bit, whether an edge or a level caused it. One interrupt line is the OR of the pending bits of every bank.

Registers are grouped by function. Address bits [7:4] select the group and address bits [3:2] select the bank, so each group holds the banks at a 4-byte stride. Reads are combinational from the address.

Top module: `gpx_top`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` and `pin_out` are 0, and `irq` is low.
- R2: Group codes in address bits [7:4] are: 0 direction, 1 inversion, 2 data, 3 raise, 4 lower, 5 rising enable, 6 falling enable, 7 high enable, 8 low enable, 9 pending, 10 edge source. Address bits [3:2] select the bank. A bank index of 3 or a group code above 10 reads 0, and writes to it change nothing.
- R3: `pin_oe` follows the direction register (1 = output). Writing the data register loads `pin_out` on the next clock edge.
- R4: Writing 1s to the raise register sets those output bits, and writing 1s to the lower register clears them. Bits written as 0 keep their value.
- R5: A data read returns the output latch for output pins and the sensed value for input pins. An input change appears in the read two clock edges after the change.
- R6: With the rising enable set, a 0-to-1 input change sets the pending bit on the third clock edge after the change.
- R7: With the falling enable set, a 1-to-0 change sets the pending bit. With both edge enables set, either edge sets it.
- R8: With the high or low enable set, the pending bit sets one edge after the level is sensed. It cannot be cleared while that level persists.
- R9: A change or level whose enable is off leaves the pending bit at 0.
- R10: Writing 1 to a pending bit clears it and writing 0 has no effect. A trigger in the same cycle as the clear wins, and the bit stays set.
- R11: An inversion bit of 1 inverts the sensed value, both for data reads and for triggers.
- R12: `irq` is high while any pending bit in any bank is set.
- R13: An edge-source bit is 1 only when its pending bit was set by an edge, 0 when a level set it, and it clears with its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address: group in [7:4], bank in [3:2] |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | 96 | Pad input levels |
| pin_out | output | 96 | Output latch values |
| pin_oe | output | 96 | Output enables |
| irq | output | 1 | Shared interrupt, OR of all pending bits |

## Verification
The results fall due at fixed clock edges:
- A register write takes effect at the edge that samples it.
- An input change reaches a data read after two edges.
- An edge trigger reaches the pending bit, and through it `irq`, on the third edge. A level trigger does the same one edge after its enable is written, if the level is already present.

The bench drives inputs on falling edges. It waits exactly the counted number of rising edges and samples at the next falling edge. It also checks the cycle just before each trigger is due, to show that the trigger is not early.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int LANE = 32;
  localparam int NGRP = 11;
  localparam int GW   = 4;

  localparam int G_DIR = 0;
  localparam int G_INV = 1;
  localparam int G_DAT = 2;
  localparam int G_RAI = 3;
  localparam int G_LOW = 4;
  localparam int G_REN = 5;
  localparam int G_FEN = 6;
  localparam int G_HEN = 7;
  localparam int G_LEN = 8;
  localparam int G_PND = 9;
  localparam int G_SRC = 10;

  typedef logic [LANE-1:0] lane_t;

  function automatic lane_t f_rise(lane_t now, lane_t was);
    return now & ~was;
  endfunction

  function automatic lane_t f_fall(lane_t now, lane_t was);
    return ~now & was;
  endfunction

  // pending bit: cleared by a 1 written to it unless a trigger arrives in the same cycle
  function automatic lane_t f_sticky(lane_t pend, lane_t clr, lane_t ev);
    return (pend & ~clr) | ev;
  endfunction

  // edge-source flag: set by an edge, dropped by a level trigger or by a clear
  function automatic lane_t f_src(lane_t src, lane_t clr, lane_t ev_e, lane_t ev_l);
    return ev_e | (src & ~ev_l & ~clr);
  endfunction

  function automatic lane_t f_rdmix(lane_t dir, lane_t outv, lane_t sense);
    return (dir & outv) | (~dir & sense);
  endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
  import gpx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NGRP-1:0]      we,
  input  lane_t                wdata,
  input  lane_t                pads,
  output lane_t                out_q,
  output lane_t                dir_q,
  output logic [NGRP-1:0][LANE-1:0] rd,
  output lane_t                ev,
  output lane_t                clr,
  output lane_t                pnd_q,
  output lane_t                src_q
);
  lane_t inv_q, ren_q, fen_q, hen_q, len_q, was_q;
  lane_t syn, sense, ev_e, ev_l;

  gpx_sync #(.W(LANE)) u_sync (.clk(clk), .rst_n(rst_n), .d(pads), .q(syn));

  assign sense = syn ^ inv_q;
  assign ev_e  = (ren_q & f_rise(sense, was_q)) | (fen_q & f_fall(sense, was_q));
  assign ev_l  = (hen_q & sense) | (len_q & ~sense);
  assign ev    = ev_e | ev_l;
  assign clr   = we[G_PND] ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0; inv_q <= '0; out_q <= '0;
      ren_q <= '0; fen_q <= '0; hen_q <= '0; len_q <= '0;
      pnd_q <= '0; src_q <= '0; was_q <= '0;
    end else begin
      was_q <= sense;
      if (we[G_DIR]) dir_q <= wdata;
      if (we[G_INV]) inv_q <= wdata;
      if (we[G_REN]) ren_q <= wdata;
      if (we[G_FEN]) fen_q <= wdata;
      if (we[G_HEN]) hen_q <= wdata;
      if (we[G_LEN]) len_q <= wdata;
      if (we[G_DAT])      out_q <= wdata;
      else if (we[G_RAI]) out_q <= out_q | wdata;
      else if (we[G_LOW]) out_q <= out_q & ~wdata;
      pnd_q <= f_sticky(pnd_q, clr, ev);
      src_q <= f_src(src_q, clr, ev_e, ev_l);
    end
  end

  always_comb begin
    rd        = '0;
    rd[G_DIR] = dir_q;
    rd[G_INV] = inv_q;
    rd[G_DAT] = f_rdmix(dir_q, out_q, sense);
    rd[G_REN] = ren_q;
    rd[G_FEN] = fen_q;
    rd[G_HEN] = hen_q;
    rd[G_LEN] = len_q;
    rd[G_PND] = pnd_q;
    rd[G_SRC] = src_q;
  end
endmodule

// File: rtl/gpx_top.sv
module gpx_top
  import gpx_pkg::*;
#(
  parameter int NBANK = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            bus_addr,
  input  logic                  bus_wen,
  input  logic [LANE-1:0]       bus_wdata,
  output logic [LANE-1:0]       bus_rdata,
  input  logic [NBANK*LANE-1:0] pin_in,
  output logic [NBANK*LANE-1:0] pin_out,
  output logic [NBANK*LANE-1:0] pin_oe,
  output logic                  irq
);
  localparam int NPIN = NBANK * LANE;

  logic [GW-1:0] grp;
  logic [1:0]    bsel;
  logic [NPIN-1:0] ev_all, clr_all, stat_all, edge_all;
  logic [NGRP-1:0][LANE-1:0] bank_rd [NBANK];

  assign grp  = bus_addr[7:4];
  assign bsel = bus_addr[3:2];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [NGRP-1:0] we_b;
    always_comb begin
      we_b = '0;
      for (int g = 0; g < NGRP; g++)
        if (bus_wen && bsel == 2'(b) && grp == GW'(g)) we_b[g] = 1'b1;
    end

    gpx_bank u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we_b),
      .wdata (bus_wdata),
      .pads  (pin_in[b*LANE +: LANE]),
      .out_q (pin_out[b*LANE +: LANE]),
      .dir_q (pin_oe[b*LANE +: LANE]),
      .rd    (bank_rd[b]),
      .ev    (ev_all[b*LANE +: LANE]),
      .clr   (clr_all[b*LANE +: LANE]),
      .pnd_q (stat_all[b*LANE +: LANE]),
      .src_q (edge_all[b*LANE +: LANE])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++)
      for (int g = 0; g < NGRP; g++)
        if (bsel == 2'(b) && grp == GW'(g)) bus_rdata = bank_rd[b][g];
  end

  assign irq = |stat_all;
endmodule

// File: rtl/gpx_chk.sv
module gpx_chk #(
  parameter int N = 96
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wen,
  input logic [N-1:0] pin_oe,
  input logic         irq,
  input logic [N-1:0] ev_all,
  input logic [N-1:0] clr_all,
  input logic [N-1:0] stat_all,
  input logic [N-1:0] edge_all
);
  // R10: a cleared bit with no trigger in that cycle is 0 afterwards
  a_r10_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_all & $past(clr_all & ~ev_all)) == '0));

  // R10: a trigger always leaves its bit set, even against a clear
  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_all & $past(ev_all)) == $past(ev_all)));

  // R9: no pending bit appears without a trigger
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_all & ~$past(stat_all) & ~$past(ev_all)) == '0));

  // R13: edge-source bits only where a bit is pending
  a_r13_src_in_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_all & ~stat_all) == '0);

  // R3: output enables move only through a bus write
  a_r3_oe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wen |=> $stable(pin_oe));

  // R12: the interrupt rises only after a trigger
  a_r12_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|ev_all));
endmodule

bind gpx_top gpx_chk #(.N(NBANK * gpx_pkg::LANE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wen  (bus_wen),
  .pin_oe   (pin_oe),
  .irq      (irq),
  .ev_all   (ev_all),
  .clr_all  (clr_all),
  .stat_all (stat_all),
  .edge_all (edge_all)
);

// File: tb/sim_gpx_top.sv
module sim_gpx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [95:0] pin_in = '0;
  logic [95:0] pin_out, pin_oe;
  logic        irq;
  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  localparam int DIR = 0, INV = 1, DAT = 2, RAI = 3, LOW = 4, REN = 5;
  localparam int FEN = 6, HEN = 7, LEN = 8, PND = 9, SRC = 10;

  gpx_top u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
              .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
              .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  always #5 clk = ~clk;

  function automatic logic [7:0] adr(int g, int b);
    return 8'(g * 16 + b * 4);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int g, int b, logic [31:0] v);
    bus_addr = adr(g, b); bus_wdata = v; bus_wen = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(int g, int b, output logic [31:0] v);
    bus_addr = adr(g, b);
    #1;
    v = bus_rdata;
  endtask

  task automatic chk_reg(string req, int g, int b, logic [31:0] exp);
    logic [31:0] v;
    rd(g, b, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    for (int b = 0; b < 3; b++)
      for (int g = 0; g < 11; g++) chk_reg("R1", g, b, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 oe", pin_oe[31:0] | pin_oe[63:32] | pin_oe[95:64], 32'h0);
    chk("R1 out", pin_out[31:0] | pin_out[63:32] | pin_out[95:64], 32'h0);
  endtask

  task automatic t_dir_data;
    wr(DIR, 1, 32'hFFFF_0000);
    wr(DAT, 1, 32'h1234_5678);
    chk("R3 oe", pin_oe[63:32], 32'hFFFF_0000);
    chk("R3 out", pin_out[63:32], 32'h1234_5678);
    chk("R2 other banks", pin_oe[31:0] | pin_oe[95:64], 32'h0);
    chk_reg("R5 mixed read", DAT, 1, 32'h1234_0000);
    chk_reg("R2 dir readback", DIR, 1, 32'hFFFF_0000);
  endtask

  task automatic t_raise_lower;
    wr(DAT, 2, 32'h0);
    wr(RAI, 2, 32'h0000_00F0);
    chk("R4 raise", pin_out[95:64], 32'h0000_00F0);
    wr(RAI, 2, 32'h3);
    chk("R4 raise keeps", pin_out[95:64], 32'h0000_00F3);
    wr(LOW, 2, 32'h30);
    chk("R4 lower", pin_out[95:64], 32'h0000_00C3);
    wr(LOW, 2, 32'h0);
    chk("R4 lower zero", pin_out[95:64], 32'h0000_00C3);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(DIR, 3, 32'hFFFF_FFFF);
    bus_addr = 8'hB0; bus_wdata = 32'hFFFF_FFFF; bus_wen = 1'b1;
    @(posedge clk); @(negedge clk); bus_wen = 1'b0;
    chk_reg("R2 bank3 reads 0", DIR, 3, 32'h0);
    bus_addr = 8'hB0; #1; v = bus_rdata;
    chk("R2 group 11 reads 0", v, 32'h0);
    chk_reg("R2 bank0 untouched", DIR, 0, 32'h0);
    chk("R2 oe untouched", pin_oe[31:0] | pin_oe[95:64], 32'h0);
  endtask

  task automatic t_read_input;
    pin_in[31:0] = 32'hA5;
    cyc(1);
    chk_reg("R5 one stage", DAT, 0, 32'h0);
    cyc(1);
    chk_reg("R5 sensed", DAT, 0, 32'hA5);
    pin_in[31:0] = '0;
    cyc(3);
  endtask

  task automatic t_rise;
    wr(REN, 0, 32'h20);
    pin_in[5] = 1'b1;
    cyc(2);
    chk_reg("R6 not early", PND, 0, 32'h0);
    cyc(1);
    chk_reg("R6 pending", PND, 0, 32'h20);
    chk("R12 irq on", {31'b0, irq}, 32'h1);
    chk_reg("R13 edge source", SRC, 0, 32'h20);
    wr(PND, 0, 32'h20);
    chk_reg("R10 cleared", PND, 0, 32'h0);
    chk_reg("R13 src cleared", SRC, 0, 32'h0);
    chk("R12 irq off", {31'b0, irq}, 32'h0);
    pin_in[5] = 1'b0;
    cyc(4);
    chk_reg("R9 fall ignored", PND, 0, 32'h0);
    wr(REN, 0, 32'h0);
  endtask

  task automatic t_fall_both;
    wr(FEN, 2, 32'h1);
    pin_in[64] = 1'b1;
    cyc(4);
    chk_reg("R9 rise ignored", PND, 2, 32'h0);
    pin_in[64] = 1'b0;
    cyc(2);
    chk_reg("R7 not early", PND, 2, 32'h0);
    cyc(1);
    chk_reg("R7 fall", PND, 2, 32'h1);
    wr(PND, 2, 32'h1);
    wr(REN, 2, 32'h1);
    pin_in[64] = 1'b1;
    cyc(3);
    chk_reg("R7 both rise", PND, 2, 32'h1);
    wr(PND, 2, 32'h1);
    chk_reg("R10 clear", PND, 2, 32'h0);
    pin_in[64] = 1'b0;
    cyc(3);
    chk_reg("R7 both fall", PND, 2, 32'h1);
    wr(PND, 2, 32'h1);
    wr(REN, 2, 32'h0);
    wr(FEN, 2, 32'h0);
    chk_reg("R10 clear", PND, 2, 32'h0);
  endtask

  task automatic t_level;
    wr(HEN, 1, 32'h8);
    pin_in[35] = 1'b1;
    cyc(3);
    chk_reg("R8 high", PND, 1, 32'h8);
    chk_reg("R13 level src", SRC, 1, 32'h0);
    wr(PND, 1, 32'h8);
    chk_reg("R8 held by level", PND, 1, 32'h8);
    pin_in[35] = 1'b0;
    cyc(3);
    wr(PND, 1, 32'h8);
    chk_reg("R10 clear after level", PND, 1, 32'h0);
    wr(LEN, 1, 32'h8);
    chk_reg("R8 low not early", PND, 1, 32'h0);
    cyc(1);
    chk_reg("R8 low", PND, 1, 32'h8);
    wr(LEN, 1, 32'h0);
    wr(HEN, 1, 32'h0);
    wr(PND, 1, 32'h8);
    chk_reg("R10 clear", PND, 1, 32'h0);
  endtask

  task automatic t_w1c_zero;
    wr(LEN, 0, 32'h200);
    cyc(1);
    wr(LEN, 0, 32'h0);
    chk_reg("R8 low set", PND, 0, 32'h200);
    wr(PND, 0, 32'h0);
    chk_reg("R10 zero write", PND, 0, 32'h200);
    wr(PND, 0, 32'h1);
    chk_reg("R10 other bit", PND, 0, 32'h200);
    wr(PND, 0, 32'h200);
    chk_reg("R10 one clears", PND, 0, 32'h0);
    chk("R12 irq off", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_inv;
    wr(INV, 0, 32'h80);
    chk_reg("R11 read inverted", DAT, 0, 32'h80);
    wr(HEN, 0, 32'h80);
    cyc(1);
    chk_reg("R11 high via inversion", PND, 0, 32'h80);
    wr(HEN, 0, 32'h0);
    wr(INV, 0, 32'h0);
    wr(PND, 0, 32'h80);
    chk_reg("R11 cleanup", PND, 0, 32'h0);
  endtask

  task automatic t_irq_multi;
    wr(REN, 0, 32'h1);
    wr(REN, 2, 32'h8000_0000);
    pin_in[0] = 1'b1;
    cyc(3);
    chk("R12 irq bank0", {31'b0, irq}, 32'h1);
    pin_in[95] = 1'b1;
    cyc(3);
    chk_reg("R6 bank2 pin31", PND, 2, 32'h8000_0000);
    wr(PND, 0, 32'h1);
    chk("R12 irq still", {31'b0, irq}, 32'h1);
    wr(PND, 2, 32'h8000_0000);
    chk("R12 irq low", {31'b0, irq}, 32'h0);
    wr(REN, 0, 32'h0);
    wr(REN, 2, 32'h0);
    pin_in[0] = 1'b0;
    pin_in[95] = 1'b0;
    cyc(3);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_dir_data();
    t_raise_lower();
    t_unmapped();
    t_read_input();
    t_rise();
    t_fall_both();
    t_level();
    t_w1c_zero();
    t_inv();
    t_irq_multi();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule